// File: doc/BRIEF.md
# Endless Phase Rotation Handover Controller

This block turns two phase-shift units into a single phase rotator with no end stops. Each unit holds an 8-bit step position that saturates at 0 and at 255, and a glitch-free clock multiplexer outside the block picks which unit drives the output clock. The controller accepts one-cycle requests to raise or lower the phase by one step. It drives a step command with a direction to both units, and it keeps the standby unit as the exact mirror of the active one. When the active unit already sits at the limit in the requested direction, the controller does not step. It flips the clock select so that the standby unit, which waits at the opposite extreme, becomes active. The two units then trade roles.

Each step command is a one-cycle pulse with a direction bit, answered by a one-cycle done pulse from the unit. The controller waits for both units to answer before it accepts the next request. After a handover it waits a programmable number of settle cycles before it accepts the next request. A signed cumulative phase counter follows every accepted request, including those that end in a handover. A steady run of requests in one direction therefore shows up as a steady frequency offset that keeps going through every handover.

Top module: `phs_handover_ctrl`

## Requirements
- R1: After synchronous reset, sel_o is 0 (unit A drives the clock), a_value_o is 0, b_value_o is 255, phase_o is 0, ready_o is 1 and no step or switch pulse is present.
- R2: An accepted request that does not hit a limit produces exactly one one-cycle step pulse on each unit. The active unit gets raise=1 for step_up_i and raise=0 for step_down_i, and the standby unit gets the opposite direction. Both values move by one, in those directions, once both done pulses have arrived.
- R3: At all times b_value_o equals 255 minus a_value_o.
- R4: A step_up_i while the active unit is at 255, or a step_down_i while it is at 0, produces no step pulse. Instead sel_o toggles (0 selects unit A, 1 selects unit B) and switch_o is high for exactly that one cycle. The unit values stay where they are, so the new active unit begins at the opposite extreme.
- R5: After a handover, ready_o stays low for settle_len_i + 1 cycles. During that time no request is accepted.
- R6: ready_o goes low in the cycle after a request is accepted and stays low until both units have returned done, however different their latencies. Requests that arrive while ready_o is low are ignored.
- R7: A cycle with step_up_i and step_down_i both high is ignored. Values, select and phase stay unchanged, and ready_o stays high.
- R8: phase_o is a signed counter. It rises by 1 for each accepted step_up_i and falls by 1 for each accepted step_down_i, handovers included, so it keeps counting past 255 while the units hand over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_up_i | input | 1 | One-cycle request to raise the phase by one step |
| step_down_i | input | 1 | One-cycle request to lower the phase by one step |
| settle_len_i | input | SETTLE_W | Extra wait cycles after a handover |
| a_step_o | output | 1 | Step command pulse to unit A |
| a_raise_o | output | 1 | Direction for unit A, 1 raises its value |
| a_done_i | input | 1 | Unit A step-complete pulse |
| b_step_o | output | 1 | Step command pulse to unit B |
| b_raise_o | output | 1 | Direction for unit B, 1 raises its value |
| b_done_i | input | 1 | Unit B step-complete pulse |
| sel_o | output | 1 | Clock select, 0 = unit A, 1 = unit B |
| switch_o | output | 1 | One-cycle pulse when the select flips |
| ready_o | output | 1 | High when a request can be accepted |
| a_value_o | output | STEP_W | Current step value of unit A |
| b_value_o | output | STEP_W | Current step value of unit B |
| phase_o | output | PHASE_W | Signed cumulative phase count |

## Verification
The properties assume that each unit returns exactly one done pulse for each step pulse, that no done pulse appears without a command, and that request pulses are single-cycle. The bench meets these assumptions with two unit models of different latencies. Each model answers only its own command, once. The bench raises requests for a single cycle at a falling edge and then waits for ready_o. Requests during a busy window are made on purpose, but only as single cycles while both unit models are still counting down.

// File: rtl/phs_pkg.sv
`timescale 1ns/1ps
package phs_pkg;

    localparam int unsigned NUM_UNITS = 2;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_STEP   = 2'd1,
        ST_SETTLE = 2'd2
    } phs_state_e;

    // Decoded request from the two pulse inputs
    typedef struct packed {
        logic valid;
        logic raise;
    } phs_req_t;

    // Command driven to one phase-shift unit
    typedef struct packed {
        logic step;
        logic raise;
    } phs_cmd_t;

    // True when the active unit cannot move further in the requested direction
    function automatic logic edge_hit(input logic raise, input logic at_top, input logic at_bot);
        return raise ? at_top : at_bot;
    endfunction

    // Direction for a unit: active follows the request, standby opposes it
    function automatic logic unit_raise(input logic req_raise, input logic is_active);
        return is_active ? req_raise : ~req_raise;
    endfunction

endpackage

// File: rtl/phs_req_filter.sv
`timescale 1ns/1ps
module phs_req_filter
    import phs_pkg::*;
(
    input  logic     up_i,
    input  logic     down_i,
    input  logic     enable_i,
    output phs_req_t req_o
);

    always_comb begin
        req_o.valid = enable_i & (up_i ^ down_i);
        req_o.raise = up_i;
    end

endmodule

// File: rtl/phs_done_join.sv
`timescale 1ns/1ps
module phs_done_join #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         arm_i,
    input  logic [N-1:0] done_i,
    output logic         all_done_o
);

    logic [N-1:0] seen_q;

    always_ff @(posedge clk) begin
        if (rst || arm_i) begin
            seen_q <= '0;
        end else begin
            seen_q <= seen_q | done_i;
        end
    end

    assign all_done_o = &(seen_q | done_i);

endmodule

// File: rtl/phs_settle_timer.sv
`timescale 1ns/1ps
module phs_settle_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] len_i,
    output logic         expired_o
);

    logic [W-1:0] cnt_q;
    logic         run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (load_i) begin
            cnt_q <= len_i;
            run_q <= 1'b1;
        end else if (run_q) begin
            if (cnt_q == '0) begin
                run_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign expired_o = run_q && (cnt_q == '0);

endmodule

// File: rtl/phs_handover_ctrl.sv
`timescale 1ns/1ps
module phs_handover_ctrl
    import phs_pkg::*;
#(
    parameter int unsigned STEP_W   = 8,
    parameter int unsigned PHASE_W  = 16,
    parameter int unsigned SETTLE_W = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      step_up_i,
    input  logic                      step_down_i,
    input  logic [SETTLE_W-1:0]       settle_len_i,
    output logic                      a_step_o,
    output logic                      a_raise_o,
    input  logic                      a_done_i,
    output logic                      b_step_o,
    output logic                      b_raise_o,
    input  logic                      b_done_i,
    output logic                      sel_o,
    output logic                      switch_o,
    output logic                      ready_o,
    output logic [STEP_W-1:0]         a_value_o,
    output logic [STEP_W-1:0]         b_value_o,
    output logic signed [PHASE_W-1:0] phase_o
);

    localparam logic [STEP_W-1:0]  VAL_MAX = {STEP_W{1'b1}};
    localparam logic [STEP_W-1:0]  VAL_MIN = '0;
    localparam logic [PHASE_W-1:0] PH_ONE  = PHASE_W'(1);

    phs_state_e          state_q;
    logic                sel_q;
    logic                switch_q;
    logic                pend_raise_q;
    logic [PHASE_W-1:0]  phase_q;
    logic [STEP_W-1:0]   val_q [NUM_UNITS];
    phs_cmd_t            cmd_q [NUM_UNITS];

    phs_req_t            req;
    logic                idle;
    logic                hit_limit;
    logic                issue;
    logic                handover;
    logic                commit;
    logic                all_done;
    logic                settle_done;
    logic [STEP_W-1:0]   act_val;
    logic [NUM_UNITS-1:0] done_vec;

    assign idle     = (state_q == ST_IDLE);
    assign done_vec = {b_done_i, a_done_i};
    assign act_val  = val_q[sel_q];

    phs_req_filter u_req (
        .up_i     (step_up_i),
        .down_i   (step_down_i),
        .enable_i (idle),
        .req_o    (req)
    );

    assign hit_limit = edge_hit(req.raise, act_val == VAL_MAX, act_val == VAL_MIN);
    assign issue     = req.valid && !hit_limit;
    assign handover  = req.valid && hit_limit;
    assign commit    = (state_q == ST_STEP) && all_done;

    phs_done_join #(.N(NUM_UNITS)) u_join (
        .clk        (clk),
        .rst        (rst),
        .arm_i      (issue),
        .done_i     (done_vec),
        .all_done_o (all_done)
    );

    phs_settle_timer #(.W(SETTLE_W)) u_settle (
        .clk       (clk),
        .rst       (rst),
        .load_i    (handover),
        .len_i     (settle_len_i),
        .expired_o (settle_done)
    );

    // Sequencing, clock select and phase accumulation
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_IDLE;
            sel_q        <= 1'b0;
            switch_q     <= 1'b0;
            pend_raise_q <= 1'b0;
            phase_q      <= '0;
        end else begin
            switch_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (issue) begin
                        pend_raise_q <= req.raise;
                        state_q      <= ST_STEP;
                    end else if (handover) begin
                        sel_q    <= ~sel_q;
                        switch_q <= 1'b1;
                        phase_q  <= req.raise ? phase_q + PH_ONE : phase_q - PH_ONE;
                        state_q  <= ST_SETTLE;
                    end
                end
                ST_STEP: begin
                    if (commit) begin
                        phase_q <= pend_raise_q ? phase_q + PH_ONE : phase_q - PH_ONE;
                        state_q <= ST_IDLE;
                    end
                end
                ST_SETTLE: begin
                    if (settle_done) begin
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Per-unit step command and value tracking
    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        logic is_act;
        assign is_act = (sel_q == 1'(u));

        always_ff @(posedge clk) begin
            if (rst) begin
                val_q[u] <= (u == 0) ? VAL_MIN : VAL_MAX;
                cmd_q[u] <= '0;
            end else begin
                cmd_q[u].step <= issue;
                if (issue) begin
                    cmd_q[u].raise <= unit_raise(req.raise, is_act);
                end
                if (commit) begin
                    val_q[u] <= unit_raise(pend_raise_q, is_act) ? val_q[u] + 1'b1
                                                                 : val_q[u] - 1'b1;
                end
            end
        end
    end

    assign a_step_o  = cmd_q[0].step;
    assign a_raise_o = cmd_q[0].raise;
    assign b_step_o  = cmd_q[1].step;
    assign b_raise_o = cmd_q[1].raise;
    assign sel_o     = sel_q;
    assign switch_o  = switch_q;
    assign ready_o   = idle;
    assign a_value_o = val_q[0];
    assign b_value_o = val_q[1];
    assign phase_o   = $signed(phase_q);

endmodule

// File: rtl/phs_handover_checker.sv
`timescale 1ns/1ps
module phs_handover_checker #(
    parameter int unsigned STEP_W  = 8,
    parameter int unsigned PHASE_W = 16
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      step_up_i,
    input logic                      step_down_i,
    input logic                      a_step_o,
    input logic                      a_raise_o,
    input logic                      b_step_o,
    input logic                      b_raise_o,
    input logic                      sel_o,
    input logic                      switch_o,
    input logic                      ready_o,
    input logic [STEP_W-1:0]         a_value_o,
    input logic [STEP_W-1:0]         b_value_o,
    input logic signed [PHASE_W-1:0] phase_o
);

    localparam logic [STEP_W:0] SUM_FULL = {1'b0, {STEP_W{1'b1}}};

    logic [PHASE_W-1:0] ph_prev_q;
    logic [PHASE_W-1:0] ph_delta;

    always_ff @(posedge clk) begin
        ph_prev_q <= phase_o;
    end
    assign ph_delta = phase_o - ph_prev_q;

    p_mirror_r3: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, a_value_o} + {1'b0, b_value_o}) == SUM_FULL);

    p_paired_step_r2: assert property (@(posedge clk) disable iff (rst)
        a_step_o |-> (b_step_o && (a_raise_o != b_raise_o)));

    p_step_single_r2: assert property (@(posedge clk) disable iff (rst)
        a_step_o |=> !a_step_o);

    p_step_from_idle_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(b_step_o) |-> $past(ready_o));

    p_switch_toggle_r4: assert property (@(posedge clk) disable iff (rst)
        switch_o |-> ((sel_o != $past(sel_o)) && !a_step_o && !b_step_o));

    p_sel_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !switch_o |-> $stable(sel_o));

    p_switch_settle_r5: assert property (@(posedge clk) disable iff (rst)
        switch_o |=> (!switch_o && !ready_o));

    p_both_ignored_r7: assert property (@(posedge clk) disable iff (rst)
        (ready_o && step_up_i && step_down_i) |=> (ready_o && $stable(phase_o)));

    p_phase_unit_r8: assert property (@(posedge clk) disable iff (rst)
        (ph_delta == '0) || (ph_delta == PHASE_W'(1)) || (ph_delta == {PHASE_W{1'b1}}));

endmodule

bind phs_handover_ctrl phs_handover_checker #(
    .STEP_W  (STEP_W),
    .PHASE_W (PHASE_W)
) u_chk (.*);

// File: tb/phs_handover_ctrl_bench.sv
`timescale 1ns/1ps
module phs_handover_ctrl_bench;

    localparam int LAT_A  = 2;
    localparam int LAT_B  = 5;
    localparam int SETTLE = 3;

    // op: 0 = up, 1 = down, 2 = both at once
    typedef struct packed {
        logic [1:0]         op;
        logic [8:0]         reps;
        logic               sel;
        logic [7:0]         a;
        logic [7:0]         b;
        logic signed [15:0] ph;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{op: 2'd0, reps: 9'd5, sel: 1'b0, a: 8'd5,   b: 8'd250, ph:  16'sd5},
        '{op: 2'd1, reps: 9'd2, sel: 1'b0, a: 8'd3,   b: 8'd252, ph:  16'sd3},
        '{op: 2'd2, reps: 9'd1, sel: 1'b0, a: 8'd3,   b: 8'd252, ph:  16'sd3},
        '{op: 2'd1, reps: 9'd3, sel: 1'b0, a: 8'd0,   b: 8'd255, ph:  16'sd0},
        '{op: 2'd1, reps: 9'd1, sel: 1'b1, a: 8'd0,   b: 8'd255, ph: -16'sd1},
        '{op: 2'd1, reps: 9'd2, sel: 1'b1, a: 8'd2,   b: 8'd253, ph: -16'sd3},
        '{op: 2'd0, reps: 9'd2, sel: 1'b1, a: 8'd0,   b: 8'd255, ph: -16'sd1},
        '{op: 2'd0, reps: 9'd1, sel: 1'b0, a: 8'd0,   b: 8'd255, ph:  16'sd0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        step_up = 1'b0;
    logic        step_down = 1'b0;
    logic [7:0]  settle_len = 8'(SETTLE);
    logic        a_step, a_raise, a_done;
    logic        b_step, b_raise, b_done;
    logic        sel, switch_p, ready;
    logic [7:0]  a_value, b_value;
    logic signed [15:0] phase;

    int checks = 0;
    int failures = 0;
    int a_pulses = 0;
    int b_pulses = 0;
    int sw_pulses = 0;
    int a_last_raise = 0;
    int b_last_raise = 0;
    logic [3:0] a_cnt_q, b_cnt_q;

    always #2.5 clk = ~clk;

    phs_handover_ctrl u_phs_handover_ctrl (
        .clk          (clk),
        .rst          (rst),
        .step_up_i    (step_up),
        .step_down_i  (step_down),
        .settle_len_i (settle_len),
        .a_step_o     (a_step),
        .a_raise_o    (a_raise),
        .a_done_i     (a_done),
        .b_step_o     (b_step),
        .b_raise_o    (b_raise),
        .b_done_i     (b_done),
        .sel_o        (sel),
        .switch_o     (switch_p),
        .ready_o      (ready),
        .a_value_o    (a_value),
        .b_value_o    (b_value),
        .phase_o      (phase)
    );

    // Unit models: one done pulse per step command, fixed latency each
    always @(posedge clk) begin
        if (rst) a_cnt_q <= '0;
        else if (a_step) a_cnt_q <= 4'(LAT_A);
        else if (a_cnt_q != 0) a_cnt_q <= a_cnt_q - 1'b1;
    end
    always @(posedge clk) begin
        if (rst) b_cnt_q <= '0;
        else if (b_step) b_cnt_q <= 4'(LAT_B);
        else if (b_cnt_q != 0) b_cnt_q <= b_cnt_q - 1'b1;
    end
    assign a_done = (a_cnt_q == 4'd1);
    assign b_done = (b_cnt_q == 4'd1);

    always @(posedge clk) begin
        if (a_step) begin a_pulses <= a_pulses + 1; a_last_raise <= int'(a_raise); end
        if (b_step) begin b_pulses <= b_pulses + 1; b_last_raise <= int'(b_raise); end
        if (switch_p) sw_pulses <= sw_pulses + 1;
    end

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_req(input int op);
        @(negedge clk);
        while (!ready) @(negedge clk);
        step_up   = (op == 0 || op == 2);
        step_down = (op == 1 || op == 2);
        @(negedge clk);
        step_up   = 1'b0;
        step_down = 1'b0;
        while (!ready) @(negedge clk);
    endtask

    task automatic chk_state(input string tag, input int s, input int a, input int b, input int ph);
        chk({tag, " sel"}, int'(sel), s);
        chk({tag, " a_value R3"}, int'(a_value), a);
        chk({tag, " b_value R3"}, int'(b_value), b);
        chk({tag, " phase R8"}, int'(phase), ph);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        int ap, bp, sp, lowc;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk_state("R1 reset", 0, 0, 255, 0);
        chk("R1 ready", int'(ready), 1);
        chk("R1 no pulses", int'(a_step | b_step | switch_p), 0);

        // Table walk: R2 R3 R4 R7 R8
        for (int v = 0; v < NVEC; v++) begin
            for (int r = 0; r < int'(VECS[v].reps); r++) do_req(int'(VECS[v].op));
            chk_state($sformatf("vec%0d R4 R7", v), int'(VECS[v].sel), int'(VECS[v].a),
                      int'(VECS[v].b), int'(VECS[v].ph));
        end

        // R2: one paired pulse per unit, opposite directions
        ap = a_pulses; bp = b_pulses;
        do_req(0);
        chk("R2 a pulses", a_pulses - ap, 1);
        chk("R2 b pulses", b_pulses - bp, 1);
        chk("R2 a raise", a_last_raise, 1);
        chk("R2 b raise", b_last_raise, 0);
        chk_state("R2 after up", 0, 1, 254, 1);
        do_req(1);
        chk("R2 a lower", a_last_raise, 0);
        chk_state("R2 after down", 0, 0, 255, 0);

        // R6: request while busy is ignored
        @(negedge clk);
        step_up = 1'b1;
        @(negedge clk);
        step_up = 1'b0;
        chk("R6 busy", int'(ready), 0);
        step_down = 1'b1;
        @(negedge clk);
        step_down = 1'b0;
        while (!ready) @(negedge clk);
        repeat (3) @(negedge clk);
        chk_state("R6 ignored", 0, 1, 254, 1);
        do_req(1);

        // R8: run up to the top of unit A
        for (int k = 0; k < 255; k++) do_req(0);
        chk_state("R8 top", 0, 255, 0, 255);

        // R4 R5: handover without step pulses and settle window
        ap = a_pulses; bp = b_pulses; sp = sw_pulses;
        @(negedge clk);
        step_up = 1'b1;
        @(negedge clk);
        step_up = 1'b0;
        chk("R4 switch high", int'(switch_p), 1);
        lowc = 0;
        while (!ready) begin lowc++; @(negedge clk); end
        chk("R5 settle cycles", lowc, SETTLE + 1);
        chk("R4 no a pulse", a_pulses - ap, 0);
        chk("R4 no b pulse", b_pulses - bp, 0);
        chk("R4 one switch", sw_pulses - sp, 1);
        chk_state("R4 handed over", 1, 255, 0, 256);

        // R8: rotation continues on unit B
        for (int k = 0; k < 3; k++) do_req(0);
        chk_state("R8 beyond", 1, 252, 3, 259);

        // R1: reset mid-run
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk_state("R1 rereset", 0, 0, 255, 0);
        chk("R1 ready again", int'(ready), 1);

        finish_run();
    end

endmodule